// File: doc/BRIEF.md
# Bus Activity and Wiring Fault Monitor

This block watches a differential serial bus through two sampled inputs: the received data level and a flag that marks the undriven rest state. From these it forms a three-state view of the bus: driven 0, driven 1 or released. It classifies whole transmissions without decoding any characters. It reports whether a transmission began with an idle-high lead-in bit and whether it ended with an extra high bit before release. From the level the bus left when it went quiet, it judges whether the two wires are swapped.

Within a transmission, every interval in the rest state is measured. A short interval is a normal bit transition. A medium interval counts as a slow edge. A long interval counts as a dip inside a character. Two more watchers look at the bus as a whole. One flags a bus that stays driven for too long without ever resting. The other flags a bus that stays released while traffic is expected, which points to a swing that is too low. All thresholds are given as clock-cycle counts on input ports. The results are held in sticky flags and saturating counters until a clear pulse arrives. A one-cycle strobe carries a summary of each transmission as it ends.

Top module: `busfault_mon`

## Requirements
- R1: After reset all flags, both counters, the summary strobe and the summary fields are 0.
- R2: A transmission starts at the first sample with `bus_rest`=0. It ends at the sample where `bus_rest`=1 has been seen for `end_lim` consecutive samples. `sum_vld` is high for exactly the one cycle after that sample.
- R3: `sum_pre` is 1 when the first driven sample of the transmission had `bus_lvl`=1, and 0 when it had `bus_lvl`=0.
- R4: `sum_post` is 1 when the number of driven-high samples since the last driven-low sample is at least `post_lim` when the transmission ends.
- R5: `sum_swap` is 1 when the last driven sample before the end was low. The same condition sets the sticky `flg_swap`. A transmission that ends from driven high leaves both at 0.
- R6: Inside a transmission, a rest interval of L samples that ends on a driven sample, with `slow_lim` < L <= `dip_lim`, adds one to `slow_cnt`. An interval with L <= `slow_lim` changes no counter.
- R7: Inside a transmission, a rest interval with L > `dip_lim` that ends on a driven sample adds one to `dip_cnt`.
- R8: `flg_norest` is set at the `norest_lim`-th consecutive driven sample and not before.
- R9: `flg_lowsw` is set at the `lowsw_lim`-th consecutive sample with both `bus_rest`=1 and `rx_expect`=1, and not before.
- R10: Flags hold until `clr` is sampled high, and `clr` zeroes the flags and counters. An event that falls in the same cycle as `clr` still takes effect: a flag is set, and a counter becomes 1.
- R11: `slow_cnt` and `dip_cnt` saturate at all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears sticky flags and counters |
| bus_lvl | input | 1 | Received data level |
| bus_rest | input | 1 | High while the bus is undriven |
| rx_expect | input | 1 | High while traffic is expected |
| slow_lim | input | TW | Longest rest interval still treated as a normal edge |
| dip_lim | input | TW | Longest rest interval still treated as a slow edge |
| end_lim | input | TW | Consecutive rest samples that end a transmission |
| post_lim | input | TW | Final high-run length that counts as a post-bit |
| norest_lim | input | TW | Consecutive driven samples that raise the no-rest flag |
| lowsw_lim | input | TW | Consecutive expected-but-undriven samples that raise the low-swing flag |
| sum_vld | output | 1 | One-cycle end-of-transmission strobe |
| sum_pre | output | 1 | Lead-in high bit present |
| sum_post | output | 1 | Trailing high bit present |
| sum_swap | output | 1 | Transmission ended from driven low |
| flg_swap | output | 1 | Sticky swapped-wire flag |
| flg_norest | output | 1 | Sticky bus-never-rests flag |
| flg_lowsw | output | 1 | Sticky swing-too-low flag |
| slow_cnt | output | CW | Saturating slow-edge count |
| dip_cnt | output | CW | Saturating dip count |

## Verification
The clear pulse can arrive in the same cycle as a detection event, and the block must resolve that collision in favour of the event. The bench provokes this twice. In the first case, `clr` is driven with the driven sample that closes a medium rest interval, and `slow_cnt` must then read 1 with `dip_cnt` at 0. In the second case, `clr` is driven with the rest sample that ends a transmission left from driven low, and `flg_swap` must read 1 while the other flags read 0. In both cases the result is read from the ports right after that edge.

// File: rtl/busfault_pkg.sv
package busfault_pkg;
  localparam int TW_DEF = 16;
  localparam int CW_DEF = 16;
  localparam int NRUN   = 3;
  localparam int NCNT   = 2;

  typedef enum logic { ST_IDLE, ST_XFER } xst_t;

  typedef struct packed {
    logic pre;
    logic post;
    logic swap;
  } xsum_t;
endpackage

// File: rtl/mon_runlen.sv
module mon_runlen #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cond,
  input  logic [TW-1:0] lim,
  output logic [TW-1:0] cnt,
  output logic          hit
);
  localparam logic [TW-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst || !cond) cnt <= '0;
    else if (cnt != MAXV) cnt <= cnt + 1'b1;
  end

  // this sample completes a run of at least lim
  always_comb hit = cond && (({1'b0, cnt} + 1'b1) >= {1'b0, lim});
endmodule

// File: rtl/mon_satcnt.sv
module mon_satcnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (rst)                      cnt <= '0;
    else if (clr)                 cnt <= inc ? CW'(1) : '0;
    else if (inc && cnt != MAXV)  cnt <= cnt + 1'b1;
  end

  p_monotone_r11: assert property (@(posedge clk) disable iff (rst)
    !clr |=> cnt >= $past(cnt));
  p_hold_max_r11: assert property (@(posedge clk) disable iff (rst)
    (cnt == MAXV && !clr) |=> cnt == MAXV);
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> cnt <= CW'(1));
endmodule

// File: rtl/mon_xfer.sv
module mon_xfer
  import busfault_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          lvl,
  input  logic          rest,
  input  logic [TW-1:0] rest_cnt,
  input  logic          end_hit,
  input  logic [TW-1:0] slow_lim,
  input  logic [TW-1:0] dip_lim,
  input  logic [TW-1:0] post_lim,
  output logic          slow_ev,
  output logic          dip_ev,
  output logic          end_swap,
  output logic          sum_vld,
  output xsum_t         sum
);
  localparam logic [TW-1:0] MAXV = '1;

  xst_t          st;
  logic          pre_q;
  logic          last_lvl;
  logic [TW-1:0] hi_run;
  logic          gap_end;
  logic          fin;

  always_comb begin
    gap_end  = (st == ST_XFER) && !rest && (rest_cnt != '0);
    slow_ev  = gap_end && (rest_cnt > slow_lim) && (rest_cnt <= dip_lim);
    dip_ev   = gap_end && (rest_cnt > dip_lim);
    fin      = (st == ST_XFER) && rest && end_hit;
    end_swap = fin && !last_lvl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      pre_q    <= 1'b0;
      last_lvl <= 1'b0;
      hi_run   <= '0;
      sum_vld  <= 1'b0;
      sum      <= '0;
    end else begin
      sum_vld <= 1'b0;
      if (st == ST_IDLE) begin
        if (!rest) begin
          st       <= ST_XFER;
          pre_q    <= lvl;
          last_lvl <= lvl;
          hi_run   <= lvl ? TW'(1) : '0;
        end
      end else if (!rest) begin
        last_lvl <= lvl;
        if (!lvl)               hi_run <= '0;
        else if (hi_run != MAXV) hi_run <= hi_run + 1'b1;
      end else if (fin) begin
        st       <= ST_IDLE;
        sum_vld  <= 1'b1;
        sum.pre  <= pre_q;
        sum.post <= (hi_run >= post_lim);
        sum.swap <= !last_lvl;
      end
    end
  end

  p_one_shot_r2: assert property (@(posedge clk) disable iff (rst)
    sum_vld |=> !sum_vld);
  p_end_idle_r2: assert property (@(posedge clk) disable iff (rst)
    sum_vld |-> st == ST_IDLE);
  p_ev_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(slow_ev && dip_ev));
endmodule

// File: rtl/busfault_mon.sv
module busfault_mon
  import busfault_pkg::*;
#(
  parameter int TW = TW_DEF,
  parameter int CW = CW_DEF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          bus_lvl,
  input  logic          bus_rest,
  input  logic          rx_expect,
  input  logic [TW-1:0] slow_lim,
  input  logic [TW-1:0] dip_lim,
  input  logic [TW-1:0] end_lim,
  input  logic [TW-1:0] post_lim,
  input  logic [TW-1:0] norest_lim,
  input  logic [TW-1:0] lowsw_lim,
  output logic          sum_vld,
  output logic          sum_pre,
  output logic          sum_post,
  output logic          sum_swap,
  output logic          flg_swap,
  output logic          flg_norest,
  output logic          flg_lowsw,
  output logic [CW-1:0] slow_cnt,
  output logic [CW-1:0] dip_cnt
);
  // run watchers: 0 rest, 1 driven, 2 expected-but-undriven
  logic [NRUN-1:0] rl_cond;
  logic [TW-1:0]   rl_lim [NRUN];
  logic [TW-1:0]   rl_cnt [NRUN];
  logic [NRUN-1:0] rl_hit;

  always_comb begin
    rl_cond[0] = bus_rest;
    rl_cond[1] = !bus_rest;
    rl_cond[2] = bus_rest && rx_expect;
    rl_lim[0]  = end_lim;
    rl_lim[1]  = norest_lim;
    rl_lim[2]  = lowsw_lim;
  end

  for (genvar i = 0; i < NRUN; i++) begin : g_run
    mon_runlen #(.TW(TW)) u_run (
      .clk (clk), .rst (rst), .cond (rl_cond[i]), .lim (rl_lim[i]),
      .cnt (rl_cnt[i]), .hit (rl_hit[i])
    );
  end

  logic  slow_ev, dip_ev, end_swap;
  xsum_t sum;

  mon_xfer #(.TW(TW)) u_xfer (
    .clk (clk), .rst (rst), .lvl (bus_lvl), .rest (bus_rest),
    .rest_cnt (rl_cnt[0]), .end_hit (rl_hit[0]),
    .slow_lim (slow_lim), .dip_lim (dip_lim), .post_lim (post_lim),
    .slow_ev (slow_ev), .dip_ev (dip_ev), .end_swap (end_swap),
    .sum_vld (sum_vld), .sum (sum)
  );

  always_comb begin
    sum_pre  = sum.pre;
    sum_post = sum.post;
    sum_swap = sum.swap;
  end

  // event counters: 0 slow edges, 1 dips
  logic [NCNT-1:0] ev;
  logic [CW-1:0]   ev_cnt [NCNT];

  always_comb ev = {dip_ev, slow_ev};

  for (genvar j = 0; j < NCNT; j++) begin : g_cnt
    mon_satcnt #(.CW(CW)) u_cnt (
      .clk (clk), .rst (rst), .clr (clr), .inc (ev[j]), .cnt (ev_cnt[j])
    );
  end

  always_comb begin
    slow_cnt = ev_cnt[0];
    dip_cnt  = ev_cnt[1];
  end

  // sticky flags: a set in the clearing cycle survives
  always_ff @(posedge clk) begin
    if (rst) begin
      flg_swap   <= 1'b0;
      flg_norest <= 1'b0;
      flg_lowsw  <= 1'b0;
    end else begin
      flg_swap   <= (flg_swap   && !clr) || end_swap;
      flg_norest <= (flg_norest && !clr) || rl_hit[1];
      flg_lowsw  <= (flg_lowsw  && !clr) || rl_hit[2];
    end
  end

  p_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ($past(flg_swap) -> flg_swap) && ($past(flg_norest) -> flg_norest)
             && ($past(flg_lowsw) -> flg_lowsw));
  p_swap_sum_r5: assert property (@(posedge clk) disable iff (rst)
    (sum_vld && sum_swap) |-> flg_swap);
  p_lowsw_need_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_lowsw) |-> $past(bus_rest && rx_expect));
  p_norest_need_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(flg_norest) |-> $past(!bus_rest));
endmodule

// File: tb/sim_busfault_mon.sv
module sim_busfault_mon;
  localparam int TW = 16;
  localparam int CW = 4;
  localparam time CLK_PER = 10ns;

  logic clk = 1'b0;
  logic rst, clr, bus_lvl, bus_rest, rx_expect;
  logic [TW-1:0] slow_lim, dip_lim, end_lim, post_lim, norest_lim, lowsw_lim;
  logic sum_vld, sum_pre, sum_post, sum_swap;
  logic flg_swap, flg_norest, flg_lowsw;
  logic [CW-1:0] slow_cnt, dip_cnt;

  int n_run = 0;
  int n_bad = 0;
  logic [2:0] exp_q [$];

  always #(CLK_PER/2) clk = ~clk;

  busfault_mon #(.TW(TW), .CW(CW)) u0 (
    .clk, .rst, .clr, .bus_lvl, .bus_rest, .rx_expect,
    .slow_lim, .dip_lim, .end_lim, .post_lim, .norest_lim, .lowsw_lim,
    .sum_vld, .sum_pre, .sum_post, .sum_swap,
    .flg_swap, .flg_norest, .flg_lowsw, .slow_cnt, .dip_cnt
  );

  task automatic chk(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge after n captures
  task automatic hold(logic lv, logic rs, logic cl, int n);
    bus_lvl = lv; bus_rest = rs; clr = cl;
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_sum(logic pre, logic post, logic swap);
    exp_q.push_back({pre, post, swap});
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && sum_vld) begin
      if (exp_q.size() == 0) chk("R2 unexpected summary", 1, 0);
      else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        chk("R3 sum_pre", sum_pre, e[2]);
        chk("R4 sum_post", sum_post, e[1]);
        chk("R5 sum_swap", sum_swap, e[0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; clr = 1'b0; bus_lvl = 1'b1; bus_rest = 1'b1; rx_expect = 1'b0;
    slow_lim = 3; dip_lim = 8; end_lim = 20; post_lim = 12;
    norest_lim = 200; lowsw_lim = 50;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1
    chk("R1 flags", {flg_swap, flg_norest, flg_lowsw}, 0);
    chk("R1 counters", slow_cnt + dip_cnt, 0);
    chk("R1 summary", {sum_vld, sum_pre, sum_post, sum_swap}, 0);
    hold(1, 1, 0, 30);

    // frame with pre-bit, post-bit, short edge (R6 ignored) and slow edge
    expect_sum(1, 1, 0);
    hold(1, 0, 0, 8); hold(0, 0, 0, 8); hold(1, 0, 0, 6);
    hold(1, 1, 0, 2);
    chk("R6 short rest ignored", slow_cnt, 0);
    hold(0, 0, 0, 8);
    hold(1, 1, 0, 5); hold(1, 0, 0, 16);
    chk("R6 slow edge", slow_cnt, 1);
    hold(1, 1, 0, 19);
    chk("R2 no end before end_lim", sum_vld, 0);
    hold(1, 1, 0, 1);
    chk("R2 strobe after end_lim", sum_vld, 1);
    hold(1, 1, 0, 1);
    chk("R2 strobe single cycle", sum_vld, 0);
    hold(1, 1, 0, 5);

    // frame without pre/post, with a dip
    expect_sum(0, 0, 0);
    hold(0, 0, 0, 8); hold(1, 0, 0, 8); hold(1, 1, 0, 12);
    hold(0, 0, 0, 8); hold(1, 0, 0, 8); hold(1, 1, 0, 25);
    chk("R7 dip counted", dip_cnt, 1);
    chk("R6 slow unchanged by dip", slow_cnt, 1);
    chk("R5 no swap on high end", flg_swap, 0);

    // swapped wires: ends from driven low
    expect_sum(1, 0, 1);
    hold(1, 0, 0, 8); hold(0, 0, 0, 16); hold(1, 1, 0, 25);
    chk("R5 swap flag", flg_swap, 1);

    // never-rest boundary
    expect_sum(1, 1, 0);
    hold(1, 0, 0, 199);
    chk("R8 not before limit", flg_norest, 0);
    hold(1, 0, 0, 1);
    chk("R8 set at limit", flg_norest, 1);
    hold(1, 1, 0, 25);

    // swing-low boundary
    rx_expect = 1'b1;
    hold(1, 1, 0, 49);
    chk("R9 not before limit", flg_lowsw, 0);
    hold(1, 1, 0, 1);
    chk("R9 set at limit", flg_lowsw, 1);
    rx_expect = 1'b0;
    hold(1, 1, 0, 5);
    chk("R10 flags sticky", {flg_swap, flg_norest, flg_lowsw}, 7);

    // clear
    hold(1, 1, 1, 1);
    hold(1, 1, 0, 1);
    chk("R10 clear flags", {flg_swap, flg_norest, flg_lowsw}, 0);
    chk("R10 clear counters", slow_cnt + dip_cnt, 0);

    // clear collides with slow-edge event
    expect_sum(0, 0, 0);
    hold(0, 0, 0, 4); hold(1, 1, 0, 5);
    hold(1, 0, 1, 1);
    chk("R10 slow event wins over clr", slow_cnt, 1);
    chk("R10 dip after clr", dip_cnt, 0);
    hold(1, 0, 0, 8); hold(1, 1, 0, 25);

    // clear collides with swapped end
    expect_sum(1, 0, 1);
    hold(1, 0, 0, 4); hold(0, 0, 0, 8); hold(1, 1, 0, 19);
    hold(1, 1, 1, 1);
    chk("R10 swap set wins over clr", flg_swap, 1);
    chk("R10 slow cleared", slow_cnt, 0);
    hold(1, 1, 0, 10);

    // saturation
    expect_sum(0, 0, 0);
    for (int k = 0; k < 17; k++) begin
      hold(0, 0, 0, 3); hold(0, 1, 0, 5);
    end
    hold(1, 0, 0, 3);
    chk("R11 slow saturates", slow_cnt, 15);
    hold(1, 1, 0, 25);
    chk("R11 stays saturated", slow_cnt, 15);
    chk("R2 all summaries seen", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule